// File: doc/BRIEF.md
# Split-Transaction Response State Updater

This block sits in the split-transaction path of a USB 2.0 host controller. It runs once for each full-speed or low-speed transaction that has completed through a hub's transaction translator. It receives the current transfer-descriptor state: direction code, data toggle, error counter, remaining byte count, current buffer offset and maximum packet length. It also receives the classified response from the translator. From these it computes the descriptor fields and status flags that are to be written back.

The schedule walker pulses `rsp_valid` for one cycle with a classified response. One clock later the block presents the new descriptor fields together with a one-cycle `upd_valid` pulse. It also gives four indications. `upd_retire` means the descriptor is finished. `upd_advance` means the queue may move to its next descriptor. `upd_hold` asks the walker to keep the asynchronous schedule parked on the same queue head, so that the complete-split retry comes first in the next micro-frame. `upd_halt` means the queue must stop.

Direction codes on `pid_code`: OUT = 0, IN = 1, SETUP = 2, and 3 is unused. Response codes on `rsp_kind`: NAK = 0, STALL = 1, DATA = 2, ACK = 3, translator/transaction error = 4, and 5 to 7 are unused. On a DATA response, `rsp_data_pid` is 0 for DATA0 and 1 for DATA1.

Top module: `split_resp_updater`

## Requirements
- R1: A NAK to an OUT or IN descriptor leaves the toggle, error counter, byte count and offset unchanged, and raises none of halt, xact_err, retire, advance or hold.
- R2: A NAK to a SETUP descriptor is an error. It raises `upd_xact_err` and decrements the 2-bit error counter. Byte count, offset and toggle are unchanged.
- R3: A STALL, for any direction, raises `upd_halt` and `upd_retire` with `upd_advance` low. Toggle, counter, byte count and offset are unchanged.
- R4: On an IN descriptor, a DATA response is accepted when `rsp_data_pid` equals the current toggle and `rsp_crc_ok` is 1. Let n be the smaller of `rsp_bytes` and the remaining byte count. When accepted, the offset grows by n modulo 4096 (12 bits), the byte count (15 bits) shrinks by n, and the toggle inverts.
- R5: On an IN descriptor, a DATA response whose PID differs from the toggle, or whose CRC is bad, is discarded. All fields are unchanged and no flag is raised.
- R6: On an OUT or SETUP descriptor, an ACK moves the offset forward by the smaller of `max_pkt` and the remaining byte count. The byte count shrinks by that same amount and the toggle inverts.
- R7: After an accepted IN packet or an ACK, `upd_retire` and `upd_advance` are both 1 when the new byte count is zero, or when an accepted IN packet carried fewer bytes than `max_pkt`. Otherwise both are 0.
- R8: A transaction error (code 4) raises `upd_xact_err` and decrements the error counter. It raises `upd_hold` when the new counter value is not zero.
- R9: The error counter saturates at zero. Any error that leaves it at zero, whether it stepped from 1 or was already 0, raises `upd_halt` with `upd_hold`, `upd_retire` and `upd_advance` low.
- R10: `upd_valid` is high exactly in the cycle after `rsp_valid`. Between updates, all `upd_*` fields keep their last values.
- R11: A response that does not fit the direction is treated as no event: ACK to IN, DATA to OUT or SETUP, any response to direction code 3, and response codes 5 to 7. Fields are copied unchanged and no flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_valid | input | 1 | One-cycle strobe: response and descriptor inputs are valid |
| pid_code | input | 2 | Descriptor direction: 0 OUT, 1 IN, 2 SETUP |
| rsp_kind | input | 3 | Response: 0 NAK, 1 STALL, 2 DATA, 3 ACK, 4 error |
| rsp_data_pid | input | 1 | Received data PID: 0 DATA0, 1 DATA1 |
| rsp_crc_ok | input | 1 | Received data packet passed CRC |
| rsp_bytes | input | 11 | Bytes received in the data packet |
| cur_toggle | input | 1 | Descriptor data toggle |
| cur_cerr | input | 2 | Descriptor error counter |
| cur_bytes | input | 15 | Remaining bytes to transfer |
| cur_offset | input | 12 | Current buffer offset |
| max_pkt | input | 11 | Endpoint maximum packet length |
| upd_valid | output | 1 | Update pulse, one cycle after `rsp_valid` |
| upd_toggle | output | 1 | New data toggle |
| upd_cerr | output | 2 | New error counter |
| upd_bytes | output | 15 | New remaining byte count |
| upd_offset | output | 12 | New buffer offset |
| upd_halt | output | 1 | Set halt status |
| upd_xact_err | output | 1 | Set transaction-error status |
| upd_retire | output | 1 | Retire the descriptor |
| upd_advance | output | 1 | Advance the queue to its next descriptor |
| upd_hold | output | 1 | Keep the asynchronous schedule on this queue head |

## Verification
The bench targets the point where NAK stops being harmless: on SETUP a NAK must cost an error count. A design that ignored the direction would let a control endpoint retry forever without ever halting. Toggle-mismatch and bad-CRC packets are sent with a large byte count, so a design that accepted them would visibly move the offset and byte count. The bench also checks the min() choice at both ends: an ACK larger than the residue and a short IN packet. A design that used the wrong operand, or skipped the short-packet test, would overrun the buffer or fail to retire. Finally, the error counter is driven through 3→2, 1→0 and 0→0. A design that wrapped the counter, or held the schedule on the last retry, would show it in `upd_cerr`, `upd_hold` or `upd_halt`.

// File: rtl/sru_pkg.sv
package sru_pkg;
  localparam logic [1:0] PID_OUT   = 2'd0;
  localparam logic [1:0] PID_IN    = 2'd1;
  localparam logic [1:0] PID_SETUP = 2'd2;

  localparam logic [2:0] RSP_NAK   = 3'd0;
  localparam logic [2:0] RSP_STALL = 3'd1;
  localparam logic [2:0] RSP_DATA  = 3'd2;
  localparam logic [2:0] RSP_ACK   = 3'd3;
  localparam logic [2:0] RSP_XERR  = 3'd4;
endpackage

// File: rtl/sru_classify.sv
module sru_classify
  import sru_pkg::*;
(
  input  logic       valid,
  input  logic [1:0] pid_code,
  input  logic [2:0] rsp_kind,
  input  logic       data_pid,
  input  logic       crc_ok,
  input  logic       toggle,
  output logic       ev_nak_plain,
  output logic       ev_nak_setup,
  output logic       ev_stall,
  output logic       ev_in_accept,
  output logic       ev_ack,
  output logic       ev_xerr
);
  logic dir_out, dir_in, dir_setup, dir_known;

  always_comb begin
    dir_out   = (pid_code == PID_OUT);
    dir_in    = (pid_code == PID_IN);
    dir_setup = (pid_code == PID_SETUP);
    dir_known = dir_out | dir_in | dir_setup;

    ev_nak_plain = valid && (rsp_kind == RSP_NAK) && (dir_out || dir_in);
    ev_nak_setup = valid && (rsp_kind == RSP_NAK) && dir_setup;
    ev_stall     = valid && (rsp_kind == RSP_STALL) && dir_known;
    ev_in_accept = valid && (rsp_kind == RSP_DATA) && dir_in &&
                   (data_pid == toggle) && crc_ok;
    ev_ack       = valid && (rsp_kind == RSP_ACK) && (dir_out || dir_setup);
    ev_xerr      = valid && (rsp_kind == RSP_XERR) && dir_known;
  end
endmodule

// File: rtl/sru_advance.sv
module sru_advance #(
  parameter int BYTES_W = 15,
  parameter int OFF_W   = 12,
  parameter int MPL_W   = 11
) (
  input  logic               is_in,
  input  logic [MPL_W-1:0]   rsp_bytes,
  input  logic [MPL_W-1:0]   max_pkt,
  input  logic [BYTES_W-1:0] cur_bytes,
  input  logic [OFF_W-1:0]   cur_offset,
  output logic [BYTES_W-1:0] nxt_bytes,
  output logic [OFF_W-1:0]   nxt_offset,
  output logic               done
);
  function automatic logic [BYTES_W-1:0] lesser(input logic [BYTES_W-1:0] a,
                                                input logic [BYTES_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  logic [BYTES_W-1:0] pkt_ext, step;
  logic               short_pkt;

  always_comb begin
    pkt_ext    = is_in ? BYTES_W'(rsp_bytes) : BYTES_W'(max_pkt);
    step       = lesser(pkt_ext, cur_bytes);
    nxt_bytes  = cur_bytes - step;
    nxt_offset = cur_offset + OFF_W'(step);
    short_pkt  = is_in && (rsp_bytes < max_pkt);
    done       = (nxt_bytes == '0) || short_pkt;
  end
endmodule

// File: rtl/sru_errcnt.sv
module sru_errcnt #(
  parameter int CERR_W = 2
) (
  input  logic [CERR_W-1:0] cur_cerr,
  output logic [CERR_W-1:0] nxt_cerr,
  output logic              exhausted
);
  always_comb begin
    nxt_cerr  = (cur_cerr == '0) ? '0 : cur_cerr - 1'b1;
    exhausted = (nxt_cerr == '0);
  end
endmodule

// File: rtl/split_resp_updater.sv
module split_resp_updater #(
  parameter int BYTES_W = 15,
  parameter int OFF_W   = 12,
  parameter int MPL_W   = 11,
  parameter int CERR_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rsp_valid,
  input  logic [1:0]         pid_code,
  input  logic [2:0]         rsp_kind,
  input  logic               rsp_data_pid,
  input  logic               rsp_crc_ok,
  input  logic [MPL_W-1:0]   rsp_bytes,
  input  logic               cur_toggle,
  input  logic [CERR_W-1:0]  cur_cerr,
  input  logic [BYTES_W-1:0] cur_bytes,
  input  logic [OFF_W-1:0]   cur_offset,
  input  logic [MPL_W-1:0]   max_pkt,
  output logic               upd_valid,
  output logic               upd_toggle,
  output logic [CERR_W-1:0]  upd_cerr,
  output logic [BYTES_W-1:0] upd_bytes,
  output logic [OFF_W-1:0]   upd_offset,
  output logic               upd_halt,
  output logic               upd_xact_err,
  output logic               upd_retire,
  output logic               upd_advance,
  output logic               upd_hold
);
  import sru_pkg::*;

  logic ev_nak_plain, ev_nak_setup, ev_stall, ev_in_accept, ev_ack, ev_xerr;
  logic adv_event, err_event, adv_done, cnt_exhausted;
  logic [BYTES_W-1:0] adv_bytes;
  logic [OFF_W-1:0]   adv_offset;
  logic [CERR_W-1:0]  dec_cerr;

  sru_classify u_cls (
    .valid        (rsp_valid),
    .pid_code     (pid_code),
    .rsp_kind     (rsp_kind),
    .data_pid     (rsp_data_pid),
    .crc_ok       (rsp_crc_ok),
    .toggle       (cur_toggle),
    .ev_nak_plain (ev_nak_plain),
    .ev_nak_setup (ev_nak_setup),
    .ev_stall     (ev_stall),
    .ev_in_accept (ev_in_accept),
    .ev_ack       (ev_ack),
    .ev_xerr      (ev_xerr)
  );

  sru_advance #(.BYTES_W(BYTES_W), .OFF_W(OFF_W), .MPL_W(MPL_W)) u_adv (
    .is_in      (pid_code == PID_IN),
    .rsp_bytes  (rsp_bytes),
    .max_pkt    (max_pkt),
    .cur_bytes  (cur_bytes),
    .cur_offset (cur_offset),
    .nxt_bytes  (adv_bytes),
    .nxt_offset (adv_offset),
    .done       (adv_done)
  );

  sru_errcnt #(.CERR_W(CERR_W)) u_err (
    .cur_cerr  (cur_cerr),
    .nxt_cerr  (dec_cerr),
    .exhausted (cnt_exhausted)
  );

  assign adv_event = ev_in_accept | ev_ack;
  assign err_event = ev_nak_setup | ev_xerr;

  logic               n_toggle, n_halt, n_xerr, n_retire, n_advance, n_hold;
  logic [CERR_W-1:0]  n_cerr;
  logic [BYTES_W-1:0] n_bytes;
  logic [OFF_W-1:0]   n_offset;
  logic               unused_nak;

  always_comb begin
    n_toggle  = adv_event ? ~cur_toggle : cur_toggle;
    n_bytes   = adv_event ? adv_bytes : cur_bytes;
    n_offset  = adv_event ? adv_offset : cur_offset;
    n_cerr    = err_event ? dec_cerr : cur_cerr;
    n_xerr    = err_event;
    n_halt    = ev_stall | (err_event & cnt_exhausted);
    n_hold    = ev_xerr & ~cnt_exhausted;
    n_advance = adv_event & adv_done;
    n_retire  = ev_stall | n_advance;
    unused_nak = ev_nak_plain;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid    <= 1'b0;
      upd_toggle   <= 1'b0;
      upd_cerr     <= '0;
      upd_bytes    <= '0;
      upd_offset   <= '0;
      upd_halt     <= 1'b0;
      upd_xact_err <= 1'b0;
      upd_retire   <= 1'b0;
      upd_advance  <= 1'b0;
      upd_hold     <= 1'b0;
    end else begin
      upd_valid <= rsp_valid;
      if (rsp_valid) begin
        upd_toggle   <= n_toggle;
        upd_cerr     <= n_cerr;
        upd_bytes    <= n_bytes;
        upd_offset   <= n_offset;
        upd_halt     <= n_halt;
        upd_xact_err <= n_xerr;
        upd_retire   <= n_retire;
        upd_advance  <= n_advance;
        upd_hold     <= n_hold;
      end
    end
  end
endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int BYTES_W = 15,
  parameter int OFF_W   = 12,
  parameter int CERR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rsp_valid,
  input logic               ev_nak_plain,
  input logic               ev_stall,
  input logic               err_event,
  input logic               cur_toggle,
  input logic [CERR_W-1:0]  cur_cerr,
  input logic [BYTES_W-1:0] cur_bytes,
  input logic [OFF_W-1:0]   cur_offset,
  input logic               upd_valid,
  input logic               upd_toggle,
  input logic [CERR_W-1:0]  upd_cerr,
  input logic [BYTES_W-1:0] upd_bytes,
  input logic [OFF_W-1:0]   upd_offset,
  input logic               upd_halt,
  input logic               upd_xact_err,
  input logic               upd_retire,
  input logic               upd_advance,
  input logic               upd_hold
);
  AST_NAK_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nak_plain |=> (upd_toggle == $past(cur_toggle)) && (upd_cerr == $past(cur_cerr)) &&
                     (upd_bytes == $past(cur_bytes)) && (upd_offset == $past(cur_offset)) &&
                     !upd_halt && !upd_xact_err && !upd_hold); // R1

  AST_STALL_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall |=> upd_halt && upd_retire && !upd_advance); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> upd_bytes <= $past(cur_bytes)); // R4

  AST_ADVANCE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    upd_advance |-> upd_retire && !upd_halt); // R7

  AST_HOLD_ONLY_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_hold |-> upd_xact_err && !upd_halt && (upd_cerr != '0)); // R8

  AST_ERR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    err_event |=> upd_xact_err && ((upd_cerr == '0) ? upd_halt : !upd_halt)); // R9

  AST_PULSE_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> upd_valid); // R10

  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |=> !upd_valid && $stable(upd_bytes) && $stable(upd_offset)); // R10
endmodule

bind split_resp_updater sru_checker #(.BYTES_W(BYTES_W), .OFF_W(OFF_W), .CERR_W(CERR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rsp_valid    (rsp_valid),
  .ev_nak_plain (ev_nak_plain),
  .ev_stall     (ev_stall),
  .err_event    (err_event),
  .cur_toggle   (cur_toggle),
  .cur_cerr     (cur_cerr),
  .cur_bytes    (cur_bytes),
  .cur_offset   (cur_offset),
  .upd_valid    (upd_valid),
  .upd_toggle   (upd_toggle),
  .upd_cerr     (upd_cerr),
  .upd_bytes    (upd_bytes),
  .upd_offset   (upd_offset),
  .upd_halt     (upd_halt),
  .upd_xact_err (upd_xact_err),
  .upd_retire   (upd_retire),
  .upd_advance  (upd_advance),
  .upd_hold     (upd_hold)
);

// File: tb/sim_split_resp_updater.sv
`timescale 1ns/1ps
module sim_split_resp_updater;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_valid = 1'b0;
  logic [1:0]  pid_code = '0;
  logic [2:0]  rsp_kind = '0;
  logic        rsp_data_pid = 1'b0;
  logic        rsp_crc_ok = 1'b0;
  logic [10:0] rsp_bytes = '0;
  logic        cur_toggle = 1'b0;
  logic [1:0]  cur_cerr = '0;
  logic [14:0] cur_bytes = '0;
  logic [11:0] cur_offset = '0;
  logic [10:0] max_pkt = '0;
  logic        upd_valid, upd_toggle, upd_halt, upd_xact_err, upd_retire, upd_advance, upd_hold;
  logic [1:0]  upd_cerr;
  logic [14:0] upd_bytes;
  logic [11:0] upd_offset;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  split_resp_updater u0 (.*);

  // packed form: valid,toggle,cerr,bytes,offset,halt,xerr,retire,advance,hold
  function automatic logic [35:0] pack(input logic v, input logic t, input logic [1:0] c,
      input logic [14:0] b, input logic [11:0] o, input logic h, input logic x,
      input logic r, input logic a, input logic hd);
    return {v, t, c, b, o, h, x, r, a, hd};
  endfunction

  task automatic expect_out(input string tag, input logic [35:0] exp);
    logic [35:0] got;
    got = pack(upd_valid, upd_toggle, upd_cerr, upd_bytes, upd_offset,
               upd_halt, upd_xact_err, upd_retire, upd_advance, upd_hold);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Drive one response; result is sampled at the next falling edge.
  task automatic fire(input logic [1:0] pid, input logic [2:0] kind, input logic dpid,
      input logic crc, input logic [10:0] rb, input logic tog, input logic [1:0] ce,
      input logic [14:0] by, input logic [11:0] of, input logic [10:0] mp);
    @(negedge clk);
    pid_code = pid; rsp_kind = kind; rsp_data_pid = dpid; rsp_crc_ok = crc;
    rsp_bytes = rb; cur_toggle = tog; cur_cerr = ce; cur_bytes = by;
    cur_offset = of; max_pkt = mp; rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    expect_out("reset", pack(0, 0, 2'd0, 15'd0, 12'd0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_nak;
    fire(2'd0, 3'd0, 0, 1, 11'd0, 1, 2'd3, 15'd100, 12'd10, 11'd64);
    expect_out("R1 nak out", pack(1, 1, 2'd3, 15'd100, 12'd10, 0, 0, 0, 0, 0));
    fire(2'd1, 3'd0, 0, 1, 11'd0, 0, 2'd2, 15'd77, 12'd5, 11'd64);
    expect_out("R1 nak in", pack(1, 0, 2'd2, 15'd77, 12'd5, 0, 0, 0, 0, 0));
    fire(2'd2, 3'd0, 0, 1, 11'd0, 0, 2'd3, 15'd8, 12'd0, 11'd64);
    expect_out("R2 nak setup", pack(1, 0, 2'd2, 15'd8, 12'd0, 0, 1, 0, 0, 0));
    fire(2'd2, 3'd0, 0, 1, 11'd0, 0, 2'd1, 15'd8, 12'd0, 11'd64);
    expect_out("R9 nak setup last", pack(1, 0, 2'd0, 15'd8, 12'd0, 1, 1, 0, 0, 0));
  endtask

  task automatic t_stall;
    for (int p = 0; p < 3; p++) begin
      fire(2'(p), 3'd1, 0, 1, 11'd0, 1, 2'd2, 15'd40, 12'd20, 11'd64);
      expect_out($sformatf("R3 stall pid%0d", p), pack(1, 1, 2'd2, 15'd40, 12'd20, 1, 0, 1, 0, 0));
    end
  endtask

  task automatic t_in_data;
    fire(2'd1, 3'd2, 0, 1, 11'd64, 0, 2'd3, 15'd200, 12'd100, 11'd64);
    expect_out("R4 in full pkt", pack(1, 1, 2'd3, 15'd136, 12'd164, 0, 0, 0, 0, 0));
    fire(2'd1, 3'd2, 1, 1, 11'd10, 1, 2'd3, 15'd200, 12'd4090, 11'd64);
    expect_out("R7 in short wrap", pack(1, 0, 2'd3, 15'd190, 12'd4, 0, 0, 1, 1, 0));
    fire(2'd1, 3'd2, 0, 1, 11'd64, 0, 2'd1, 15'd64, 12'd0, 11'd64);
    expect_out("R7 in last exact", pack(1, 1, 2'd1, 15'd0, 12'd64, 0, 0, 1, 1, 0));
    fire(2'd1, 3'd2, 1, 1, 11'd64, 0, 2'd3, 15'd500, 12'd30, 11'd64);
    expect_out("R5 toggle mismatch", pack(1, 0, 2'd3, 15'd500, 12'd30, 0, 0, 0, 0, 0));
    fire(2'd1, 3'd2, 0, 0, 11'd64, 0, 2'd3, 15'd500, 12'd30, 11'd64);
    expect_out("R5 bad crc", pack(1, 0, 2'd3, 15'd500, 12'd30, 0, 0, 0, 0, 0));
  endtask

  task automatic t_ack;
    fire(2'd0, 3'd3, 0, 1, 11'd0, 0, 2'd3, 15'd1000, 12'd0, 11'd512);
    expect_out("R6 ack out", pack(1, 1, 2'd3, 15'd488, 12'd512, 0, 0, 0, 0, 0));
    fire(2'd2, 3'd3, 0, 1, 11'd0, 0, 2'd3, 15'd8, 12'd0, 11'd64);
    expect_out("R6 ack setup residue", pack(1, 1, 2'd3, 15'd0, 12'd8, 0, 0, 1, 1, 0));
  endtask

  task automatic t_mismatch;
    fire(2'd1, 3'd3, 0, 1, 11'd0, 0, 2'd3, 15'd300, 12'd9, 11'd64);
    expect_out("R11 ack to in", pack(1, 0, 2'd3, 15'd300, 12'd9, 0, 0, 0, 0, 0));
    fire(2'd0, 3'd2, 0, 1, 11'd20, 0, 2'd3, 15'd300, 12'd9, 11'd64);
    expect_out("R11 data to out", pack(1, 0, 2'd3, 15'd300, 12'd9, 0, 0, 0, 0, 0));
    fire(2'd2, 3'd6, 0, 1, 11'd20, 1, 2'd1, 15'd300, 12'd9, 11'd64);
    expect_out("R11 unused kind", pack(1, 1, 2'd1, 15'd300, 12'd9, 0, 0, 0, 0, 0));
    fire(2'd3, 3'd4, 0, 1, 11'd20, 1, 2'd1, 15'd300, 12'd9, 11'd64);
    expect_out("R11 unused pid", pack(1, 1, 2'd1, 15'd300, 12'd9, 0, 0, 0, 0, 0));
  endtask

  task automatic t_xerr;
    fire(2'd1, 3'd4, 0, 1, 11'd0, 1, 2'd3, 15'd50, 12'd7, 11'd64);
    expect_out("R8 xerr retry", pack(1, 1, 2'd2, 15'd50, 12'd7, 0, 1, 0, 0, 1));
    fire(2'd0, 3'd4, 0, 1, 11'd0, 1, 2'd1, 15'd50, 12'd7, 11'd64);
    expect_out("R9 xerr exhaust", pack(1, 1, 2'd0, 15'd50, 12'd7, 1, 1, 0, 0, 0));
    fire(2'd2, 3'd4, 0, 1, 11'd0, 0, 2'd0, 15'd50, 12'd7, 11'd64);
    expect_out("R9 xerr saturate", pack(1, 0, 2'd0, 15'd50, 12'd7, 1, 1, 0, 0, 0));
  endtask

  task automatic t_idle;
    fire(2'd0, 3'd3, 0, 1, 11'd0, 0, 2'd3, 15'd100, 12'd0, 11'd64);
    expect_out("R10 pulse", pack(1, 1, 2'd3, 15'd36, 12'd64, 0, 0, 0, 0, 0));
    cur_bytes = 15'd999; cur_offset = 12'd999; cur_toggle = 1'b0;
    @(negedge clk);
    expect_out("R10 hold idle", pack(0, 1, 2'd3, 15'd36, 12'd64, 0, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_nak();
    t_stall();
    t_in_data();
    t_ack();
    t_mismatch();
    t_xerr();
    t_idle();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule